// File: doc/BRIEF.md
# Per-Core IRQ/FIQ Interrupt Router

This block takes the interrupt requests produced around a four-core cluster and steers each of them onto one core's normal interrupt line (IRQ) or fast interrupt line (FIQ). The inputs are:

- four generic-timer events per core;
- four mailbox words per core;
- one performance-monitor request per core;
- a GPU request;
- a cluster bus-error request;
- a bus-quiet request;
- a local-timer request.

A routed event lands on exactly one of the two lines of its target core. When both of its enables are set, the fast line takes it.

Software programs the routing through a simple synchronous write port with a combinational read port. The read port also exposes, per core, an IRQ source word and a FIQ source word. A handler reads these words to see which routed, currently active requests are driving its pins. Each core's IRQ pin is the OR of its IRQ source word, and its FIQ pin is the OR of its FIQ source word. The router holds no event state, so the pins follow the inputs with no register delay.

Register map (5-bit word address, data in bits 7:0 unless noted):

| Address | Contents |
|---|---|
| 0 | bus-error mask, bit 0 |
| 1 | bus-error target selector, bits 2:0 |
| 2 | local-timer target selector, bits 2:0 |
| 3 | performance-monitor word, set alias |
| 4 | performance-monitor word, clear alias |
| 8+C | timer routing mask of core C |
| 12+C | mailbox routing mask of core C |
| 16+C | IRQ source word of core C (read only) |
| 20+C | FIQ source word of core C (read only) |

Top module: `irq_fanout_router`

## Requirements
- R1: After reset every routing register reads 0. With the bus-error request low, no timer, mailbox or performance-monitor activity reaches any IRQ or FIQ pin.
- R2: For each of a core's four timer events k, mask bit 4+k routes event k to that core's FIQ. Bit k routes it to that core's IRQ only when bit 4+k is clear. Source bit k reflects the result.
- R3: Core C's mailboxes are mailboxes 4C..4C+3. A mailbox is active when any bit of its word is nonzero. Mailbox-mask bit j enables IRQ and bit 4+j enables FIQ, with FIQ taking precedence. The result appears at source bit 4+j.
- R4: At address 3, each written 1 sets the matching bit of the 8-bit performance-monitor word. At address 4, each written 1 clears it. Zero bits leave the word unchanged, and both addresses read back the word.
- R5: In the performance-monitor word, bit N is the IRQ enable and bit 4+N the FIQ enable of core N, with FIQ taking precedence. Core N's request reaches only core N's source bit 9.
- R6: The bus-error selector sends an unmasked bus-error request to the IRQ of core s for codes s = 0..3, and to the FIQ of core s-4 for codes 4..7. It sets source bit 30 there and nowhere else.
- R7: While the bus-error mask bit is 1, the bus-error request reaches no pin and no source word.
- R8: The local-timer selector uses the same 3-bit code as R6 and sets source bit 11 of its single target.
- R9: The GPU request always sets IRQ source bit 8 of core 0, and the bus-quiet request always sets IRQ source bit 10 of core 0. Neither reaches any FIQ word.
- R10: Source words use a common layout: bits 3:0 timers, 7:4 mailboxes, 8 GPU, 9 performance monitor, 10 bus quiet, 11 local timer, 30 bus error. All other bits read 0. Each pin equals the OR of its source word.
- R11: No event ever sets the same source bit of one core in both its IRQ and its FIQ word at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe |
| wr_addr | input | 5 | write word address |
| wr_data | input | 32 | write data, bits 7:0 used |
| rd_addr | input | 5 | read word address |
| rd_data | output | 32 | combinational read data |
| tmr_evt | input | 16 | timer events, core C at bits 4C+3..4C |
| mbox_word | input | 64 | mailbox words, mailbox m at bits 4m+3..4m |
| pmu_req | input | 4 | performance-monitor request per core |
| gpu_req | input | 1 | GPU request |
| buserr_req | input | 1 | cluster bus-error request |
| quiet_req | input | 1 | bus-quiet request |
| ltimer_req | input | 1 | local-timer request |
| irq | output | 4 | IRQ pin per core |
| fiq | output | 4 | FIQ pin per core |

## Verification
The hardest situation to reach is one where every source of a core is active together and every enable pair has both bits set. Only then can a precedence slip put the same event on both lines of that core. The bench programs all masks and the performance-monitor word to all ones and raises every input at once. It then reads each core's two source words through the read port and checks that they share no bit.

A related case covers the selectors. The bench sweeps all eight selector codes with the bus-error request held high, so that a wrong core or pin choice shows up on the pins.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int REG_AW = 5;
    localparam logic [REG_AW-1:0] A_ERRMASK = 5'd0;
    localparam logic [REG_AW-1:0] A_ERRSEL  = 5'd1;
    localparam logic [REG_AW-1:0] A_LTSEL   = 5'd2;
    localparam logic [REG_AW-1:0] A_PMUSET  = 5'd3;
    localparam logic [REG_AW-1:0] A_PMUCLR  = 5'd4;
    localparam logic [REG_AW-1:0] A_TMR     = 5'd8;
    localparam logic [REG_AW-1:0] A_MBX     = 5'd12;
    localparam logic [REG_AW-1:0] A_ISRC    = 5'd16;
    localparam logic [REG_AW-1:0] A_FSRC    = 5'd20;
    // source-word bit positions
    localparam int B_GPU   = 8;
    localparam int B_PMU   = 9;
    localparam int B_QUIET = 10;
    localparam int B_LTMR  = 11;
    localparam int B_BERR  = 30;
endpackage

// File: rtl/irq_pair_route.sv
module irq_pair_route #(
    parameter int W = 4
) (
    input  logic [W-1:0] evt,
    input  logic [W-1:0] irq_en,
    input  logic [W-1:0] fiq_en,
    output logic [W-1:0] irq_hit,
    output logic [W-1:0] fiq_hit
);
    // fast line wins: IRQ only when the FIQ enable is clear
    always_comb begin
        fiq_hit = evt & fiq_en;
        irq_hit = evt & irq_en & ~fiq_en;
    end
endmodule

// File: rtl/irq_target_decode.sv
module irq_target_decode #(
    parameter int NCORE = 4,
    parameter int SEL_W = 3
) (
    input  logic             req,
    input  logic [SEL_W-1:0] sel,
    output logic [NCORE-1:0] to_irq,
    output logic [NCORE-1:0] to_fiq
);
    localparam int IDX_W = SEL_W - 1;

    always_comb begin
        to_irq = '0;
        to_fiq = '0;
        if (req) begin
            if (sel[SEL_W-1]) to_fiq[sel[IDX_W-1:0]] = 1'b1;
            else              to_irq[sel[IDX_W-1:0]] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [7:0]              wr_byte,
    output logic [NCORE-1:0][7:0]   tmr_mask,
    output logic [NCORE-1:0][7:0]   mbx_mask,
    output logic [2*NCORE-1:0]      pmu_word,
    output logic                    err_mask,
    output logic [SEL_W-1:0]        err_sel,
    output logic [SEL_W-1:0]        lt_sel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_mask <= '0;
            mbx_mask <= '0;
            pmu_word <= '0;
            err_mask <= 1'b0;
            err_sel  <= '0;
            lt_sel   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ERRMASK: err_mask <= wr_byte[0];
                A_ERRSEL:  err_sel  <= wr_byte[SEL_W-1:0];
                A_LTSEL:   lt_sel   <= wr_byte[SEL_W-1:0];
                A_PMUSET:  pmu_word <= pmu_word | wr_byte[2*NCORE-1:0];
                A_PMUCLR:  pmu_word <= pmu_word & ~wr_byte[2*NCORE-1:0];
                default: ;
            endcase
            for (int c = 0; c < NCORE; c++) begin
                if (wr_addr == A_TMR + REG_AW'(c)) tmr_mask[c] <= wr_byte;
                if (wr_addr == A_MBX + REG_AW'(c)) mbx_mask[c] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/irq_fanout_router.sv
module irq_fanout_router
    import irq_router_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int MBOX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [4:0]                  wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [4:0]                  rd_addr,
    output logic [31:0]                 rd_data,
    input  logic [NCORE*4-1:0]          tmr_evt,
    input  logic [NCORE*4*MBOX_W-1:0]   mbox_word,
    input  logic [NCORE-1:0]            pmu_req,
    input  logic                        gpu_req,
    input  logic                        buserr_req,
    input  logic                        quiet_req,
    input  logic                        ltimer_req,
    output logic [NCORE-1:0]            irq,
    output logic [NCORE-1:0]            fiq
);
    localparam int SEL_W = $clog2(2 * NCORE);
    localparam int NMB   = NCORE * 4;

    logic [NCORE-1:0][7:0]  tmr_mask_q;
    logic [NCORE-1:0][7:0]  mbx_mask_q;
    logic [2*NCORE-1:0]     pmu_word_q;
    logic                   err_mask_q;
    logic [SEL_W-1:0]       err_sel_q;
    logic [SEL_W-1:0]       lt_sel_q;
    logic [NMB-1:0]         mb_act;
    logic [NCORE-1:0]       err_irq, err_fiq, lt_irq, lt_fiq;
    logic [NCORE-1:0][31:0] irq_src;
    logic [NCORE-1:0][31:0] fiq_src;
    logic                   unused_wr_hi;

    assign unused_wr_hi = ^wr_data[31:8];

    irq_router_regs #(.NCORE(NCORE), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_byte(wr_data[7:0]), .tmr_mask(tmr_mask_q), .mbx_mask(mbx_mask_q),
        .pmu_word(pmu_word_q), .err_mask(err_mask_q), .err_sel(err_sel_q),
        .lt_sel(lt_sel_q)
    );

    irq_target_decode #(.NCORE(NCORE), .SEL_W(SEL_W)) u_err_dec (
        .req(buserr_req & ~err_mask_q), .sel(err_sel_q),
        .to_irq(err_irq), .to_fiq(err_fiq)
    );

    irq_target_decode #(.NCORE(NCORE), .SEL_W(SEL_W)) u_lt_dec (
        .req(ltimer_req), .sel(lt_sel_q),
        .to_irq(lt_irq), .to_fiq(lt_fiq)
    );

    for (genvar m = 0; m < NMB; m++) begin : g_mb
        assign mb_act[m] = |mbox_word[m*MBOX_W +: MBOX_W];
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [3:0] tm_i, tm_f, mb_i, mb_f;
        logic       pm_i, pm_f;
        logic       gpu_c, quiet_c;

        assign gpu_c   = (c == 0) ? gpu_req   : 1'b0;
        assign quiet_c = (c == 0) ? quiet_req : 1'b0;

        irq_pair_route #(.W(4)) u_tm (
            .evt(tmr_evt[c*4 +: 4]), .irq_en(tmr_mask_q[c][3:0]),
            .fiq_en(tmr_mask_q[c][7:4]), .irq_hit(tm_i), .fiq_hit(tm_f)
        );
        irq_pair_route #(.W(4)) u_mb (
            .evt(mb_act[c*4 +: 4]), .irq_en(mbx_mask_q[c][3:0]),
            .fiq_en(mbx_mask_q[c][7:4]), .irq_hit(mb_i), .fiq_hit(mb_f)
        );
        irq_pair_route #(.W(1)) u_pm (
            .evt(pmu_req[c]), .irq_en(pmu_word_q[c]),
            .fiq_en(pmu_word_q[NCORE+c]), .irq_hit(pm_i), .fiq_hit(pm_f)
        );

        assign irq_src[c] = {1'b0, err_irq[c], 18'b0, lt_irq[c], quiet_c,
                             pm_i, gpu_c, mb_i, tm_i};
        assign fiq_src[c] = {1'b0, err_fiq[c], 18'b0, lt_fiq[c], 1'b0,
                             pm_f, 1'b0, mb_f, tm_f};
        assign irq[c] = |irq_src[c];
        assign fiq[c] = |fiq_src[c];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_ERRMASK:          rd_data[0]              = err_mask_q;
            A_ERRSEL:           rd_data[SEL_W-1:0]      = err_sel_q;
            A_LTSEL:            rd_data[SEL_W-1:0]      = lt_sel_q;
            A_PMUSET, A_PMUCLR: rd_data[2*NCORE-1:0]    = pmu_word_q;
            default: ;
        endcase
        for (int c = 0; c < NCORE; c++) begin
            if (rd_addr == A_TMR  + 5'(c)) rd_data = {24'b0, tmr_mask_q[c]};
            if (rd_addr == A_MBX  + 5'(c)) rd_data = {24'b0, mbx_mask_q[c]};
            if (rd_addr == A_ISRC + 5'(c)) rd_data = irq_src[c];
            if (rd_addr == A_FSRC + 5'(c)) rd_data = fiq_src[c];
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NCORE = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [4:0]              wr_addr,
    input logic [7:0]              wr_byte,
    input logic                    gpu_req,
    input logic [NCORE-1:0]        irq,
    input logic                    err_mask,
    input logic [2*NCORE-1:0]      pmu_word,
    input logic [NCORE-1:0][31:0]  irq_src,
    input logic [NCORE-1:0][31:0]  fiq_src
);
    logic [2*NCORE-1:0] err_hits;

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            err_hits[c]       = irq_src[c][B_BERR];
            err_hits[NCORE+c] = fiq_src[c][B_BERR];
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_c
        p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_src[c] & fiq_src[c]) == 32'd0);
    end

    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_hits));

    p_err_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_mask |-> (err_hits == '0));

    p_pmu_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PMUSET) |=>
        pmu_word == ($past(pmu_word) | $past(wr_byte[2*NCORE-1:0])));

    p_pmu_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PMUCLR) |=>
        pmu_word == ($past(pmu_word) & ~$past(wr_byte[2*NCORE-1:0])));

    p_gpu_core0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gpu_req |-> irq[0]);
endmodule

bind irq_fanout_router irq_router_chk #(.NCORE(NCORE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_data[7:0]), .gpu_req(gpu_req), .irq(irq),
    .err_mask(err_mask_q), .pmu_word(pmu_word_q),
    .irq_src(irq_src), .fiq_src(fiq_src)
);

// File: tb/sim_irq_fanout_router.sv
module sim_irq_fanout_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] tmr_evt = '0;
    logic [63:0] mbox_word = '0;
    logic [3:0]  pmu_req = '0;
    logic        gpu_req = 1'b0, buserr_req = 1'b0, quiet_req = 1'b0, ltimer_req = 1'b0;
    logic [3:0]  irq, fiq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_fanout_router u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_evt(tmr_evt), .mbox_word(mbox_word), .pmu_req(pmu_req),
        .gpu_req(gpu_req), .buserr_req(buserr_req), .quiet_req(quiet_req),
        .ltimer_req(ltimer_req), .irq(irq), .fiq(fiq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = {24'hFFFFFF, d};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic quiet_all();
        tmr_evt = '0; mbox_word = '0; pmu_req = '0;
        gpu_req = 0; buserr_req = 0; quiet_req = 0; ltimer_req = 0;
    endtask

    task automatic t_reset_r1();
        logic [31:0] d;
        rd(5'd3, d);  chk("R1 pmu word reset", d, 0);
        rd(5'd8, d);  chk("R1 timer mask reset", d, 0);
        rd(5'd1, d);  chk("R1 err sel reset", d, 0);
        tmr_evt = '1; mbox_word = '1; pmu_req = '1;
        settle();
        chk("R1 irq quiet", {28'b0, irq}, 0);
        chk("R1 fiq quiet", {28'b0, fiq}, 0);
        quiet_all();
    endtask

    task automatic t_timer_r2();
        logic [31:0] d;
        wr(5'd9, 8'h13);
        tmr_evt[7:4] = 4'b0011;
        tmr_evt[3:0] = 4'b1111;
        rd(5'd17, d); chk("R2 irq src core1", d, 32'h2);
        rd(5'd21, d); chk("R2 fiq src core1", d, 32'h1);
        chk("R2 irq pins", {28'b0, irq}, 32'h2);
        chk("R2 fiq pins", {28'b0, fiq}, 32'h2);
        tmr_evt = 16'h0010;
        settle();
        chk("R2 fiq wins irq pin", {28'b0, irq}, 0);
        chk("R2 fiq wins fiq pin", {28'b0, fiq}, 32'h2);
        wr(5'd9, 8'h00);
        quiet_all();
    endtask

    task automatic t_mailbox_r3();
        logic [31:0] d;
        wr(5'd14, 8'h82);
        mbox_word[9*4 +: 4]  = 4'b0100;
        mbox_word[10*4 +: 4] = 4'b0001;
        mbox_word[11*4 +: 4] = 4'b1000;
        mbox_word[1*4 +: 4]  = 4'b1111;
        rd(5'd18, d); chk("R3 irq src core2", d, 32'h20);
        rd(5'd22, d); chk("R3 fiq src core2", d, 32'h80);
        chk("R3 other cores silent", {28'b0, irq & 4'b1011}, 0);
        wr(5'd14, 8'hA2);
        rd(5'd18, d); chk("R3 fiq precedence irq", d, 32'h0);
        rd(5'd22, d); chk("R3 fiq precedence fiq", d, 32'hA0);
        wr(5'd14, 8'h00);
        quiet_all();
    endtask

    task automatic t_pmu_alias_r4();
        logic [31:0] d;
        wr(5'd3, 8'h05); rd(5'd3, d); chk("R4 set 05", d, 32'h05);
        wr(5'd3, 8'h30); rd(5'd4, d); chk("R4 set 30", d, 32'h35);
        wr(5'd4, 8'h14); rd(5'd3, d); chk("R4 clr 14", d, 32'h21);
        wr(5'd4, 8'h00); rd(5'd3, d); chk("R4 clr zero", d, 32'h21);
        wr(5'd3, 8'h00); rd(5'd3, d); chk("R4 set zero", d, 32'h21);
    endtask

    task automatic t_pmu_route_r5();
        logic [31:0] d;
        wr(5'd3, 8'h10);
        pmu_req = 4'b0111;
        rd(5'd16, d); chk("R5 core0 irq src", d, 32'h0);
        rd(5'd20, d); chk("R5 core0 fiq src", d, 32'h200);
        rd(5'd21, d); chk("R5 core1 fiq src", d, 32'h200);
        rd(5'd18, d); chk("R5 core2 no route", d, 32'h0);
        chk("R5 irq pins", {28'b0, irq}, 0);
        wr(5'd4, 8'hFF); wr(5'd3, 8'h01);
        pmu_req = 4'b0010;
        settle();
        chk("R5 own core only", {28'b0, irq | fiq}, 0);
        wr(5'd4, 8'hFF);
        quiet_all();
    endtask

    task automatic t_buserr_r6();
        buserr_req = 1'b1;
        for (int s = 0; s < 8; s++) begin
            logic [31:0] d;
            wr(5'd1, 8'(s));
            rd(5'(s < 4 ? 16 + s : 20 + s - 4), d);
            chk("R6 source bit 30", d, 32'h4000_0000);
            chk("R6 irq pins", {28'b0, irq}, s < 4 ? 32'(1 << s) : 0);
            chk("R6 fiq pins", {28'b0, fiq}, s >= 4 ? 32'(1 << (s - 4)) : 0);
        end
        quiet_all();
    endtask

    task automatic t_errmask_r7();
        logic [31:0] d;
        wr(5'd1, 8'd2);
        wr(5'd0, 8'h01);
        buserr_req = 1'b1;
        rd(5'd18, d); chk("R7 masked source", d, 0);
        chk("R7 masked pins", {24'b0, irq, fiq}, 0);
        wr(5'd0, 8'h00);
        settle();
        chk("R7 unmasked", {28'b0, irq}, 32'h4);
        quiet_all();
    endtask

    task automatic t_ltimer_r8();
        logic [31:0] d;
        wr(5'd2, 8'd6);
        ltimer_req = 1'b1;
        rd(5'd22, d); chk("R8 fiq core2 bit11", d, 32'h800);
        chk("R8 pins", {24'b0, irq, fiq}, 32'h04);
        wr(5'd2, 8'd1);
        rd(5'd17, d); chk("R8 irq core1 bit11", d, 32'h800);
        quiet_all();
    endtask

    task automatic t_fixed_r9();
        logic [31:0] d;
        gpu_req = 1'b1;
        rd(5'd16, d); chk("R9 gpu bit8", d, 32'h100);
        chk("R9 gpu pin", {24'b0, irq, fiq}, 32'h10);
        gpu_req = 1'b0; quiet_req = 1'b1;
        rd(5'd16, d); chk("R9 quiet bit10", d, 32'h400);
        rd(5'd20, d); chk("R9 quiet no fiq", d, 0);
        quiet_all();
    endtask

    task automatic t_layout_r10();
        logic [31:0] d;
        wr(5'd11, 8'hF0); wr(5'd15, 8'h0F); wr(5'd3, 8'h08);
        wr(5'd2, 8'd3);   wr(5'd1, 8'd3);
        tmr_evt[15:12] = 4'hF; mbox_word[63:48] = '1; pmu_req = 4'b1000;
        ltimer_req = 1; buserr_req = 1;
        rd(5'd19, d); chk("R10 irq layout core3", d, 32'h4000_0AF0);
        rd(5'd23, d); chk("R10 fiq layout core3", d, 32'h0000_000F);
        chk("R10 pins OR", {24'b0, irq, fiq}, 32'h88);
        wr(5'd4, 8'hFF);
        quiet_all();
    endtask

    task automatic t_excl_r11();
        for (int c = 0; c < 4; c++) begin
            wr(5'(8 + c), 8'hFF); wr(5'(12 + c), 8'hFF);
        end
        wr(5'd3, 8'hFF);
        tmr_evt = '1; mbox_word = '1; pmu_req = '1;
        gpu_req = 1; quiet_req = 1; ltimer_req = 1; buserr_req = 1;
        for (int c = 0; c < 4; c++) begin
            logic [31:0] di, df;
            rd(5'(16 + c), di); rd(5'(20 + c), df);
            chk("R11 no shared bit", di & df, 0);
            chk("R11 fiq holds all", df & 32'hFF, 32'hFF);
        end
        quiet_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_timer_r2();
        t_mailbox_r3();
        t_pmu_alias_r4();
        t_pmu_route_r5();
        t_buserr_r6();
        t_errmask_r7();
        t_ltimer_r8();
        t_fixed_r9();
        t_layout_r10();
        t_excl_r11();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule